// File: doc/BRIEF.md
# Multiplexed Grid Scanner with Digital Dimming

This block scans a two- or three-grid multiplexed display from a fast oscillator clock. A prescaler divides the clock into bit times. Each grid owns a slot of 2^DIM_W bit times, and the grids take their slots one after another. For the active grid, the block drives its segment latch onto the segment lines for the first `dim_val` bit times of the slot. That pulse width sets the brightness.

The grid pre-drive lines are active low. Each grid is enabled for its slot minus a short blanking tail, so no two grids are ever on at the same time. In master mode the block exports the brightness pulse on `dim_out` and a two-bit code naming the active grid on `sync_out1`/`sync_out2`. A second unit strapped as slave takes those signals on `dim_in`/`sync_in1`/`sync_in2`. The slave ignores its own timebase, picks its segment latch from the incoming code and gates it with the incoming pulse. This lets two units drive one display in lock step.

Top module: `vfd_grid_scanner`

## Requirements
- R1: One bit time lasts OSC_PER_BIT clocks. The bit position within a slot advances by one once every bit time.
- R2: A slot lasts 2^DIM_W bit times. Slots run grid 1, grid 2, then grid 3 when `duplex_sel`=0 (three grids), and wrap after grid 2 when `duplex_sel`=1 (two grids).
- R3: `grid_n` is active low, with bit 0 for grid 1 and bit 2 for grid 3. In master mode the grid of the current slot is low for the first 2^DIM_W−BLANK_BITS bit times of the slot and high for the rest. All other grids stay high, so at most one bit is ever low.
- R4: In master mode, `seg` equals the active grid's latch while the bit position is below `dim_val`, and is zero otherwise. With `dim_val`=0 the segments stay zero for the whole slot.
- R5: In master mode, `dim_out` is high exactly while the bit position is below `dim_val`.
- R6: In master mode, (`sync_out1`,`sync_out2`) gives the active slot for the whole slot: (1,0) for grid 1, (0,1) for grid 2 and (1,1) for grid 3.
- R7: In slave mode, `seg` is the latch chosen by (`sync_in1`,`sync_in2`) ANDed with `dim_in`. The code is the same as in R6, and (0,0) selects no latch, which gives zero.
- R8: In slave mode, `grid_n` is all ones and `dim_out`, `sync_out1` and `sync_out2` are low.
- R9: In master mode, `dim_in`, `sync_in1` and `sync_in2` have no effect on any output.
- R10: While `rst` is high, `grid_n` is all ones and `seg`, `dim_out` and the sync outputs are zero. After reset the scan starts at bit 0 of the grid 1 slot.
- R11: All outputs are registered. They show the state that the timebase and the inputs had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duplex_sel | input | 1 | 1: two grids, 0: three grids |
| master_sel | input | 1 | 1: master, 0: slave |
| dim_val | input | DIM_W | Segment pulse width in bit times per slot |
| seg_data_g1 | input | SEG_W | Segment latch for grid 1 |
| seg_data_g2 | input | SEG_W | Segment latch for grid 2 |
| seg_data_g3 | input | SEG_W | Segment latch for grid 3 |
| dim_in | input | 1 | Brightness pulse from a master (slave mode) |
| sync_in1 | input | 1 | Grid code bit 1 from a master (slave mode) |
| sync_in2 | input | 1 | Grid code bit 2 from a master (slave mode) |
| grid_n | output | 3 | Active-low grid pre-drive, bit 0 = grid 1 |
| seg | output | SEG_W | Segment drive, high = lit |
| dim_out | output | 1 | Brightness pulse for a slave |
| sync_out1 | output | 1 | Grid code bit 1 for a slave |
| sync_out2 | output | 1 | Grid code bit 2 for a slave |

## Verification
In master mode every output changes at clock edges only. After the n-th edge since reset release, the outputs show bit number floor((n−1)/OSC_PER_BIT) counted from the start of grid 1. The bench derives the position, the slot and the expected levels arithmetically from n. The slave-mode results and the change from master to slave fall due at the first edge after the inputs change. The bench drives all inputs and samples all outputs on falling edges, so each check lands half a clock after the edge that must produce its value. A small configuration is swept exhaustively: every dimming value in both grid counts over two display cycles, and every sync-code and pulse-input combination in slave mode.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int GRID_CNT = 3;

  typedef logic [1:0] grid_code_t;

  // slot 0/1/2 -> code 1/2/3 ; bit 0 of the code is sync line 1
  function automatic grid_code_t slot_to_code(input logic [1:0] slot);
    return grid_code_t'(slot + 2'd1);
  endfunction
endpackage

// File: rtl/vfd_scan_timebase.sv
module vfd_scan_timebase #(
  parameter int DIM_W       = 10,
  parameter int OSC_PER_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duplex_sel,
  output logic [DIM_W-1:0] pos,
  output logic [1:0]       slot,
  output logic             bit_tick
);
  localparam int DIV_W = (OSC_PER_BIT > 1) ? $clog2(OSC_PER_BIT) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OSC_PER_BIT - 1);
  localparam logic [DIM_W-1:0] POS_LAST = '1;

  logic [DIV_W-1:0] div_q;
  logic [1:0]       last_slot;

  assign bit_tick  = (div_q == DIV_LAST);
  assign last_slot = duplex_sel ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pos   <= '0;
      slot  <= '0;
    end else begin
      if (bit_tick) div_q <= '0;
      else          div_q <= div_q + 1'b1;
      if (bit_tick) begin
        pos <= pos + 1'b1;
        if (pos == POS_LAST) begin
          if (slot >= last_slot) slot <= '0;
          else                   slot <= slot + 2'd1;
        end
      end
    end
  end

  // R1: bit position advances by one at each bit tick
  assert_bit_step_R1: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> pos == DIM_W'($past(pos) + 1'b1));
  // R1: bit position holds between ticks
  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(pos));
  // R2: slot index never names a grid beyond the third
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
    slot <= 2'd2);
endmodule

// File: rtl/vfd_scan_pulse.sv
module vfd_scan_pulse #(
  parameter int DIM_W      = 10,
  parameter int BLANK_BITS = 5
) (
  input  logic [DIM_W-1:0] pos,
  input  logic [1:0]       slot,
  input  logic [DIM_W-1:0] dim_val,
  output logic             seg_gate,
  output logic [2:0]       grid_on
);
  localparam int ON_END = (2 ** DIM_W) - BLANK_BITS;
  localparam logic [DIM_W:0] ON_END_V = (DIM_W + 1)'(ON_END);

  logic window;

  assign seg_gate = (pos < dim_val);
  assign window   = ({1'b0, pos} < ON_END_V);

  for (genvar g = 0; g < 3; g++) begin : g_grid
    assign grid_on[g] = window && (slot == 2'(g));
  end
endmodule

// File: rtl/vfd_scan_latch_sel.sv
module vfd_scan_latch_sel #(
  parameter int SEG_W = 56
) (
  input  logic [1:0]       code,
  input  logic [SEG_W-1:0] lat_g1,
  input  logic [SEG_W-1:0] lat_g2,
  input  logic [SEG_W-1:0] lat_g3,
  output logic [SEG_W-1:0] lat_out
);
  always_comb begin
    unique case (code)
      2'd1:    lat_out = lat_g1;
      2'd2:    lat_out = lat_g2;
      2'd3:    lat_out = lat_g3;
      default: lat_out = '0;
    endcase
  end
endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W       = 56,
  parameter int DIM_W       = 10,
  parameter int OSC_PER_BIT = 4,
  parameter int BLANK_BITS  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duplex_sel,
  input  logic             master_sel,
  input  logic [DIM_W-1:0] dim_val,
  input  logic [SEG_W-1:0] seg_data_g1,
  input  logic [SEG_W-1:0] seg_data_g2,
  input  logic [SEG_W-1:0] seg_data_g3,
  input  logic             dim_in,
  input  logic             sync_in1,
  input  logic             sync_in2,
  output logic [2:0]       grid_n,
  output logic [SEG_W-1:0] seg,
  output logic             dim_out,
  output logic             sync_out1,
  output logic             sync_out2
);
  logic [DIM_W-1:0] pos;
  logic [1:0]       slot;
  logic             bit_tick;
  logic             m_gate;
  logic [2:0]       m_grid_on;
  grid_code_t       m_code;
  grid_code_t       sel_code;
  logic [SEG_W-1:0] lat_sel;
  logic             gate;

  vfd_scan_timebase #(.DIM_W(DIM_W), .OSC_PER_BIT(OSC_PER_BIT)) u_timebase (
    .clk(clk), .rst(rst), .duplex_sel(duplex_sel),
    .pos(pos), .slot(slot), .bit_tick(bit_tick)
  );

  vfd_scan_pulse #(.DIM_W(DIM_W), .BLANK_BITS(BLANK_BITS)) u_pulse (
    .pos(pos), .slot(slot), .dim_val(dim_val),
    .seg_gate(m_gate), .grid_on(m_grid_on)
  );

  assign m_code   = slot_to_code(slot);
  assign sel_code = master_sel ? m_code : {sync_in2, sync_in1};
  assign gate     = master_sel ? m_gate : dim_in;

  vfd_scan_latch_sel #(.SEG_W(SEG_W)) u_latch_sel (
    .code(sel_code), .lat_g1(seg_data_g1), .lat_g2(seg_data_g2),
    .lat_g3(seg_data_g3), .lat_out(lat_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_n    <= '1;
      seg       <= '0;
      dim_out   <= 1'b0;
      sync_out1 <= 1'b0;
      sync_out2 <= 1'b0;
    end else begin
      seg <= gate ? lat_sel : '0;
      if (master_sel) begin
        grid_n    <= ~m_grid_on;
        dim_out   <= m_gate;
        sync_out1 <= m_code[0];
        sync_out2 <= m_code[1];
      end else begin
        grid_n    <= '1;
        dim_out   <= 1'b0;
        sync_out1 <= 1'b0;
        sync_out2 <= 1'b0;
      end
    end
  end

  // R3: never two grids enabled together
  assert_one_grid_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(~grid_n) <= 1);
  // R8: slave keeps grids off and exported lines low
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !master_sel |=> (grid_n == 3'b111 && !dim_out && !sync_out1 && !sync_out2));
  // R5: in master mode, lit segments only inside the brightness pulse
  assert_seg_in_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    master_sel |=> (dim_out || seg == '0));
  // R6: master always names some grid on the sync pair
  assert_sync_named_R6: assert property (@(posedge clk) disable iff (rst)
    master_sel |=> (sync_out1 || sync_out2));
endmodule

// File: tb/vfd_grid_scanner_bench.sv
`timescale 1ns/1ps
module vfd_grid_scanner_bench;
  localparam int SEG_W = 12;
  localparam int DIM_W = 4;
  localparam int OSC   = 2;
  localparam int BLANK = 2;
  localparam int SLOT  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             duplex_sel = 1'b0;
  logic             master_sel = 1'b1;
  logic [DIM_W-1:0] dim_val = '0;
  logic [SEG_W-1:0] seg_data_g1 = 12'hA53;
  logic [SEG_W-1:0] seg_data_g2 = 12'h3C6;
  logic [SEG_W-1:0] seg_data_g3 = 12'hF0F;
  logic             dim_in = 1'b0;
  logic             sync_in1 = 1'b0;
  logic             sync_in2 = 1'b0;
  logic [2:0]       grid_n;
  logic [SEG_W-1:0] seg;
  logic             dim_out;
  logic             sync_out1;
  logic             sync_out2;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vfd_grid_scanner #(.SEG_W(SEG_W), .DIM_W(DIM_W), .OSC_PER_BIT(OSC), .BLANK_BITS(BLANK))
  u_vfd_grid_scanner (
    .clk(clk), .rst(rst), .duplex_sel(duplex_sel), .master_sel(master_sel),
    .dim_val(dim_val), .seg_data_g1(seg_data_g1), .seg_data_g2(seg_data_g2),
    .seg_data_g3(seg_data_g3), .dim_in(dim_in), .sync_in1(sync_in1),
    .sync_in2(sync_in2), .grid_n(grid_n), .seg(seg), .dim_out(dim_out),
    .sync_out1(sync_out1), .sync_out2(sync_out2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [SEG_W-1:0] lat_of(input int s);
    if (s == 0) return seg_data_g1;
    if (s == 1) return seg_data_g2;
    return seg_data_g3;
  endfunction

  // master sweep: R1 R2 R3 R4 R5 R6 R9 R10 R11
  task automatic run_master(input logic dup, input logic [DIM_W-1:0] dv);
    int ng;
    int total;
    int b;
    int p;
    int s;
    logic [2:0] eg;
    ng = dup ? 2 : 3;
    total = ng * SLOT * OSC * 2;
    @(negedge clk);
    rst = 1'b1; duplex_sel = dup; master_sel = 1'b1; dim_val = dv;
    @(posedge clk); @(negedge clk);
    check("R10 reset grid_n", 32'(grid_n), 32'h7);
    check("R10 reset seg/dim/sync", {seg, dim_out, sync_out1, sync_out2}, 32'h0);
    rst = 1'b0;
    for (int n = 1; n <= total; n++) begin
      dim_in = n[1]; sync_in1 = n[2]; sync_in2 = n[0] ^ n[3];  // R9 noise
      @(posedge clk); @(negedge clk);
      b = (n - 1) / OSC;
      p = b % SLOT;
      s = (b / SLOT) % ng;
      eg = 3'b111;
      if (p < SLOT - BLANK) eg[s] = 1'b0;
      check("R3 R2 R11 grid_n", 32'(grid_n), 32'(eg));
      check("R4 R9 seg", 32'(seg), (p < int'(dv)) ? 32'(lat_of(s)) : 32'h0);
      check("R5 dim_out", 32'(dim_out), (p < int'(dv)) ? 32'h1 : 32'h0);
      check("R6 sync pair", {sync_out2, sync_out1}, 32'(s + 1));
    end
  endtask

  // slave sweep: R7 R8 R11
  task automatic run_slave();
    logic [1:0] code;
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        code = 2'(c);
        @(negedge clk);
        master_sel = 1'b0; sync_in1 = code[0]; sync_in2 = code[1]; dim_in = d[0];
        @(posedge clk); @(negedge clk);
        check("R7 slave seg", 32'(seg),
              (d == 1 && c != 0) ? 32'(lat_of(c - 1)) : 32'h0);
        check("R8 slave grid_n", 32'(grid_n), 32'h7);
        check("R8 slave dim/sync", {dim_out, sync_out1, sync_out2}, 32'h0);
      end
    end
  endtask

  initial begin
    for (int dup = 0; dup < 2; dup++) begin
      for (int dv = 0; dv < SLOT; dv++) begin
        run_master(dup[0], DIM_W'(dv));
      end
    end
    run_slave();
    duplex_sel = 1'b1;
    run_slave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule